// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address into a physical address by reading a three-level radix page table held in memory. A client presents a 64-bit virtual address, an access type (read, write or execute) and a privilege flag that says whether the access comes from user or supervisor mode. The walker takes the page number of the top-level table from a root-pointer input and reads up to three 64-bit entries through a simple request/response memory port. It checks each entry as it arrives and finishes with either a 56-bit physical address or a page-fault indication.

Only bits 38:0 of the virtual address take part in translation. Bits 11:0 are the offset inside a 4 KB page, and three 9-bit indices select one 8-byte entry in each 512-entry table: bits 38:30 at the top level, 29:21 at the middle level and 20:12 at the last level. An entry holds its flags in bits 9:0 and a 44-bit physical page number in bits 53:10. Flag bit 0 is valid, bit 1 read, bit 2 write, bit 3 execute and bit 4 user. Only one walk runs at a time, and each walk ends with a single-cycle done pulse.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and in the first cycle after it is released, req_ready is high and mem_req_valid and done are low.
- R2: A request is accepted only while req_ready is high, and req_ready stays low from the cycle after acceptance until the walk's done pulse. Only one walk is in flight at any time.
- R3: The first read goes to address {root_ppn, 12'h000} + 8*va[38:30]. Each later read goes to {ppn of the previous entry, 12'h000} + 8*index, where the index is va[29:21] and then va[20:12].
- R4: Once mem_req_valid is raised, it and mem_req_addr stay unchanged until the cycle in which mem_req_ready is high.
- R5: An entry with bit 0 clear ends the walk with a fault, and no further reads are made.
- R6: A valid entry with bits 3:1 all zero points to the next level when it is found at the top or middle level. Such an entry found at the last level is a fault.
- R7: A valid entry with any of bits 3:1 set that is found at the top or middle level is a fault. There are no large pages.
- R8: A leaf at the last level needs the permission bit that matches the access type. Type 0 is read and needs bit 1, type 1 is write and needs bit 2, type 2 is execute and needs bit 3. Type 3 always faults.
- R9: A user access (req_user=1) also needs entry bit 4. A supervisor access ignores bit 4.
- R10: On success, done_pa is {leaf entry bits 53:10, va[11:0]}. Virtual address bits 63:39 and entry bits 63:54 and 9:5 have no effect.
- R11: done is high for exactly one cycle, the cycle after the last response is taken. When done_fault is high, done_pa is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_ppn | input | 44 | Physical page number of the top-level table, sampled when a request is accepted |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker is idle and can accept a request |
| req_va | input | 64 | Virtual address to translate |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| req_user | input | 1 | 1 for a user-mode access, 0 for supervisor |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 56 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle pulse at the end of a walk |
| done_pa | output | 56 | Translated physical address, zero on a fault |
| done_fault | output | 1 | Walk ended in a page fault |

## Verification
The assertions assume that memory returns exactly one response for each accepted read, and only while the walker is waiting for it. A stray mem_rsp_valid at another time is ignored by the design, but the pulse and ordering properties are written for a well-behaved memory. The bench's memory model returns every response in the cycle after the read handshake and never sends one unasked. It also drops mem_req_ready in a fixed pattern, so that read requests are held for several cycles. The root pointer stays constant within each walk, because the bench changes it only between walks.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // Entry flag positions
  localparam int FLG_V = 0;
  localparam int FLG_R = 1;
  localparam int FLG_W = 2;
  localparam int FLG_X = 3;
  localparam int FLG_U = 4;
  localparam int FLAG_W = 10;

  // Access type codes
  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  typedef enum logic [1:0] {
    PTE_BAD  = 2'd0,
    PTE_NEXT = 2'd1,
    PTE_LEAF = 2'd2
  } pte_verdict_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int OFF_W     = 12,
  parameter int IDX_W     = 9,
  parameter int LEVELS    = 3,
  parameter int PPN_W     = 44,
  parameter int PTE_BYTES = 8,
  localparam int VA_USED  = OFF_W + IDX_W * LEVELS,
  localparam int LVL_W    = $clog2(LEVELS),
  localparam int PA_W     = PPN_W + OFF_W
) (
  input  logic [VA_USED-1:0] va,
  input  logic [LVL_W-1:0]   level,
  input  logic [PPN_W-1:0]   base_ppn,
  output logic [PA_W-1:0]    entry_addr
);
  localparam int ENT_SH = $clog2(PTE_BYTES);

  // Index field for a level: level 0 sits just above the page offset
  function automatic logic [IDX_W-1:0] pick_index(input logic [VA_USED-1:0] v,
                                                   input logic [LVL_W-1:0] lv);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (lv == LVL_W'(l)) r = v[OFF_W + IDX_W*l +: IDX_W];
    end
    return r;
  endfunction

  // Table base (page number shifted up by the offset width) plus index times entry size
  function automatic logic [PA_W-1:0] form_addr(input logic [PPN_W-1:0] ppn,
                                                 input logic [IDX_W-1:0] idx);
    return {ppn, {OFF_W{1'b0}}} + (PA_W'(idx) << ENT_SH);
  endfunction

  assign entry_addr = form_addr(base_ppn, pick_index(va, level));
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
#(
  parameter int PTE_W = 64,
  parameter int PPN_W = 44
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             last_level,
  input  logic [1:0]       acc,
  input  logic             user,
  output pte_verdict_e     verdict,
  output logic [PPN_W-1:0] next_ppn
);
  logic f_v, f_r, f_w, f_x, f_u;
  logic is_pointer, perm_ok;
  logic unused_pte_bits;

  assign f_v = pte[FLG_V];
  assign f_r = pte[FLG_R];
  assign f_w = pte[FLG_W];
  assign f_x = pte[FLG_X];
  assign f_u = pte[FLG_U];
  assign is_pointer = !(f_r || f_w || f_x);
  assign next_ppn = pte[FLAG_W +: PPN_W];
  assign unused_pte_bits = ^{pte[PTE_W-1:FLAG_W+PPN_W], pte[FLAG_W-1:FLG_U+1]};

  function automatic logic access_allowed(input logic [1:0] a, input logic r,
                                          input logic w, input logic x);
    case (a)
      ACC_READ:  return r;
      ACC_WRITE: return w;
      ACC_EXEC:  return x;
      default:   return 1'b0;
    endcase
  endfunction

  assign perm_ok = access_allowed(acc, f_r, f_w, f_x) && (!user || f_u);

  always_comb begin
    if (!f_v)              verdict = PTE_BAD;
    else if (is_pointer)   verdict = last_level ? PTE_BAD : PTE_NEXT;
    else if (!last_level)  verdict = PTE_BAD;
    else if (!perm_ok)     verdict = PTE_BAD;
    else                   verdict = PTE_LEAF;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int IDX_W     = 9,
  parameter int LEVELS    = 3,
  parameter int PPN_W     = 44,
  parameter int PTE_W     = 64,
  parameter int REQ_VA_W  = 64,
  localparam int PA_W     = PPN_W + OFF_W,
  localparam int VA_USED  = OFF_W + IDX_W * LEVELS,
  localparam int LVL_W    = $clog2(LEVELS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PPN_W-1:0]    root_ppn,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [REQ_VA_W-1:0] req_va,
  input  logic [1:0]          req_acc,
  input  logic                req_user,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [PA_W-1:0]     mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [PTE_W-1:0]    mem_rsp_data,
  output logic                done,
  output logic [PA_W-1:0]     done_pa,
  output logic                done_fault
);
  walk_state_e        st_q;
  logic [VA_USED-1:0] va_q;
  logic [1:0]         acc_q;
  logic               user_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [PPN_W-1:0]   base_q;
  logic               done_q, fault_q;
  logic [PA_W-1:0]    pa_q;

  // Named internal events
  logic walk_accept, mem_fire, rsp_take, last_level;
  pte_verdict_e verdict;
  logic [PPN_W-1:0] next_ppn;
  logic unused_va_hi;

  assign unused_va_hi = ^req_va[REQ_VA_W-1:VA_USED];
  assign req_ready     = (st_q == S_IDLE);
  assign mem_req_valid = (st_q == S_ISSUE);
  assign walk_accept   = req_valid && req_ready;
  assign mem_fire      = mem_req_valid && mem_req_ready;
  assign rsp_take      = (st_q == S_WAIT) && mem_rsp_valid;
  assign last_level    = (lvl_q == '0);

  ptw_addr_gen #(
    .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS), .PPN_W(PPN_W), .PTE_BYTES(PTE_W/8)
  ) u_addr (
    .va(va_q), .level(lvl_q), .base_ppn(base_q), .entry_addr(mem_req_addr)
  );

  ptw_pte_check #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_check (
    .pte(mem_rsp_data), .last_level(last_level), .acc(acc_q), .user(user_q),
    .verdict(verdict), .next_ppn(next_ppn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      va_q    <= '0;
      acc_q   <= '0;
      user_q  <= 1'b0;
      lvl_q   <= '0;
      base_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      pa_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (walk_accept) begin
          va_q   <= req_va[VA_USED-1:0];
          acc_q  <= req_acc;
          user_q <= req_user;
          base_q <= root_ppn;
          lvl_q  <= LVL_W'(LEVELS - 1);
          st_q   <= S_ISSUE;
        end
        S_ISSUE: if (mem_fire) st_q <= S_WAIT;
        S_WAIT: if (rsp_take) begin
          case (verdict)
            PTE_NEXT: begin
              base_q <= next_ppn;
              lvl_q  <= lvl_q - LVL_W'(1);
              st_q   <= S_ISSUE;
            end
            PTE_LEAF: begin
              done_q  <= 1'b1;
              fault_q <= 1'b0;
              pa_q    <= {next_ppn, va_q[OFF_W-1:0]};
              st_q    <= S_IDLE;
            end
            default: begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
              pa_q    <= '0;
              st_q    <= S_IDLE;
            end
          endcase
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign done       = done_q;
  assign done_pa    = pa_q;
  assign done_fault = fault_q;

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault) |-> (done_pa == '0));

  // R11
  done_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_rsp_valid));

  // R10
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_fault) |-> (done_pa[OFF_W-1:0] == va_q[OFF_W-1:0]));

  // R2
  accept_starts_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_accept |=> (mem_req_valid && !req_ready));
endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [43:0] root_ppn = 44'h100;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [63:0] req_va = '0;
  logic [1:0] req_acc = '0;
  logic req_user = 1'b0;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [55:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic done;
  logic [55:0] done_pa;
  logic done_fault;

  always #4 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .root_ppn(root_ppn),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_acc(req_acc), .req_user(req_user),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_pa(done_pa),
    .done_fault(done_fault)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Memory model
  logic [63:0] mem [logic [55:0]];
  int rd_cnt = 0;
  logic [55:0] rd_last = '0;

  function automatic logic [55:0] taddr(input logic [43:0] ppn, input int idx);
    return {ppn, 12'h000} + 56'(idx * 8);
  endfunction
  function automatic logic [63:0] mkpte(input logic [43:0] ppn, input logic [9:0] fl);
    return {10'h000, ppn, fl};
  endfunction
  function automatic logic [63:0] mkva(input int a, input int b, input int c, input int off);
    return {25'h0, a[8:0], b[8:0], c[8:0], off[11:0]};
  endfunction

  typedef struct {
    logic [55:0] pa;
    bit fault;
    int nreads;
    logic [55:0] last;
    string rq;
  } exp_t;
  exp_t sb[$];

  // Independent walk over the model, written from the requirements
  function automatic exp_t ref_walk(input logic [63:0] va, input logic [1:0] acc,
                                    input bit user, input string rq);
    exp_t e;
    logic [43:0] ppn = root_ppn;
    e.pa = '0; e.fault = 1; e.nreads = 0; e.last = '0; e.rq = rq;
    for (int lvl = 2; lvl >= 0; lvl--) begin
      logic [55:0] a;
      logic [63:0] ent;
      bit perm;
      a = taddr(ppn, int'((va >> (12 + 9*lvl)) & 64'h1FF));
      ent = mem.exists(a) ? mem[a] : 64'h0;
      e.nreads++;
      e.last = a;
      if (!ent[0]) return e;
      if (ent[3:1] == 3'b000) begin
        if (lvl == 0) return e;
        ppn = ent[53:10];
        continue;
      end
      if (lvl != 0) return e;
      perm = (acc == 2'd0) ? ent[1] : (acc == 2'd1) ? ent[2] : (acc == 2'd2) ? ent[3] : 1'b0;
      if (!perm || (user && !ent[4])) return e;
      e.fault = 0;
      e.pa = {ent[53:10], va[11:0]};
      return e;
    end
    return e;
  endfunction

  // Driver: push expectation, then present the request
  task automatic walk(input logic [63:0] va, input logic [1:0] acc, input bit user,
                      input string rq);
    sb.push_back(ref_walk(va, acc, user, rq));
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_acc = acc; req_user = user;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R2: busy right after acceptance
    chk(req_ready == 1'b0, "R2", "req_ready after accept", 64'(req_ready), 64'h0);
  endtask

  // Memory responder with a stalling ready pattern
  initial begin
    int cyc = 0;
    bit pend = 0;
    bit held = 0;
    logic [55:0] held_addr = '0;
    logic [55:0] paddr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = pend;
      mem_rsp_data = (pend && mem.exists(paddr)) ? mem[paddr] : 64'h0;
      pend = 0;
      if (held) begin
        // R4: request held while not accepted
        chk(mem_req_valid && mem_req_addr == held_addr, "R4", "held request addr",
            64'(mem_req_addr), 64'(held_addr));
      end
      mem_req_ready = (cyc % 3) != 1;
      held = mem_req_valid && !mem_req_ready;
      held_addr = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1;
        paddr = mem_req_addr;
        rd_cnt++;
        rd_last = mem_req_addr;
      end
    end
  end

  // Monitor: compare each done against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        exp_t e;
        if (sb.size() == 0) begin
          chk(1'b0, "R2", "unexpected done", 64'h1, 64'h0);
        end else begin
          e = sb.pop_front();
          chk(done_fault == e.fault, e.rq, "fault", 64'(done_fault), 64'(e.fault));
          chk(done_pa == e.pa, e.rq, "pa", 64'(done_pa), 64'(e.pa));
          chk(rd_cnt == e.nreads, e.rq, "read count", 64'(rd_cnt), 64'(e.nreads));
          chk(rd_last == e.last, "R3", "last entry addr", 64'(rd_last), 64'(e.last));
        end
        rd_cnt = 0;
        @(negedge clk);
        chk(done == 1'b0, "R11", "done single cycle", 64'(done), 64'h0);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Table setup
    mem[taddr(44'h100, 1)]   = mkpte(44'h200, 10'h001);
    mem[taddr(44'h200, 2)]   = mkpte(44'h300, 10'h001);
    mem[taddr(44'h300, 3)]   = mkpte(44'hABCDE, 10'h3F7) | 64'hFFC0_0000_0000_0000;
    mem[taddr(44'h300, 4)]   = mkpte(44'h12345, 10'h009);
    mem[taddr(44'h300, 6)]   = mkpte(44'h777, 10'h001);
    mem[taddr(44'h100, 2)]   = mkpte(44'h888, 10'h003);
    mem[taddr(44'h200, 8)]   = mkpte(44'h999, 10'h007);
    mem[taddr(44'h100, 3)]   = mkpte(44'h400, 10'h001);
    mem[taddr(44'h400, 0)]   = mkpte(44'h500, 10'h001);
    mem[taddr(44'h500, 511)] = mkpte(44'hFFF_FFFF_FFFF, 10'h01F);

    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(req_ready == 1'b1, "R1", "req_ready in reset", 64'(req_ready), 64'h1);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid in reset", 64'(mem_req_valid), 64'h0);
    chk(done == 1'b0, "R1", "done in reset", 64'(done), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !mem_req_valid && !done, "R1", "idle after reset",
        64'({req_ready, mem_req_valid, done}), 64'h4);

    walk(mkva(1, 2, 3, 12'h5A5), 2'd0, 1'b1, "R3");
    walk(mkva(1, 2, 3, 12'h010), 2'd1, 1'b0, "R8");
    walk(mkva(1, 2, 3, 12'h020), 2'd2, 1'b0, "R8");
    walk(mkva(1, 2, 3, 12'h030), 2'd3, 1'b0, "R8");
    walk(mkva(1, 2, 3, 12'hFFF) | 64'hA5A5_A580_0000_0000, 2'd0, 1'b0, "R10");
    walk(mkva(1, 2, 4, 12'h123), 2'd2, 1'b0, "R8");
    walk(mkva(1, 2, 4, 12'h123), 2'd2, 1'b1, "R9");
    walk(mkva(1, 2, 4, 12'h124), 2'd0, 1'b0, "R8");
    walk(mkva(1, 2, 3, 12'h040), 2'd0, 1'b0, "R9");
    walk(mkva(1, 2, 5, 12'h000), 2'd0, 1'b0, "R5");
    walk(mkva(7, 0, 0, 12'h000), 2'd0, 1'b0, "R5");
    walk(mkva(2, 0, 0, 12'h000), 2'd0, 1'b0, "R7");
    walk(mkva(1, 8, 0, 12'h000), 2'd0, 1'b0, "R7");
    walk(mkva(1, 2, 6, 12'h000), 2'd0, 1'b0, "R6");
    walk(mkva(3, 0, 511, 12'hFFF), 2'd0, 1'b1, "R3");
    // Root pointer change between walks: the middle table becomes the root
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    root_ppn = 44'h200;
    walk(mkva(8, 0, 0, 12'h000), 2'd0, 1'b0, "R7");
    walk(mkva(2, 3, 0, 12'h000), 2'd0, 1'b0, "R3");

    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule